// File: doc/BRIEF.md
# Windowed DMA Address Sequencer

This block generates the address stream for one side of a DMA transfer, either the read side or the write side. A start pulse loads a base address, a beat count, a hold enable and a two-bit window code. After that the block offers one address per beat on a valid/ready output. With hold clear, the addresses climb by one per beat from the base. With hold set, the offset from the base counts modulo a window of 1, 2, 4 or 8. The address therefore returns to the programmed base after every window, so that a small FIFO-like target can be hit repeatedly. When the last address is accepted, a one-cycle done pulse follows. The data path is not part of this block.

Two instances are normally placed side by side, one for each side of the transfer. In the channel mode word, the read-side window code occupies bits 15:14 and the write-side window code occupies bits 17:16. The parent slices the matching field into `cfg_win_code`. Software that wants hold mode off clears the hold enable, and it does so whatever the code holds. Back-pressure follows the usual stream rule. An address that is offered stays offered and unchanged until `addr_ready` is seen high at a clock edge. The block never withdraws an address it has offered, and it never advances without a handshake. `start` and `done` are plain control pins.

Top module: `dma_addr_hold_gen`

## Requirements
- R1: After reset, `addr_valid` and `done` are low, and they stay low until a start pulse arrives.
- R2: A start pulse seen while the block is idle with a nonzero count raises `addr_valid` in the next cycle, and the first address offered equals the loaded base.
- R3: With the hold enable clear, the k-th accepted address (k counted from 0) is base+k, whatever value `cfg_win_code` holds.
- R4: With the hold enable set and window code c, the k-th address is base + (k mod 2^c). Code 0 gives the base on every beat, and code 3 gives a window of 8.
- R5: Address arithmetic is modulo 2^AW, and the base needs no alignment to the window. An unaligned base still wraps back to exactly the programmed base.
- R6: While `addr_valid` is high and `addr_ready` is low, `addr_valid` stays high and `addr_out` holds its value.
- R7: Exactly the loaded count of addresses is offered. In the cycle after the final accepted beat, `done` is high for one cycle and `addr_valid` is low.
- R8: A start pulse with a count of zero offers no address and gives a `done` pulse in the following cycle.
- R9: A start pulse that arrives while a run is active is ignored. It neither restarts the current run nor queues a new one.
- R10: The configuration inputs are sampled only when a run is accepted. Changing them during a run has no effect on the addresses that run produces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run with the present configuration (accepted only when idle) |
| cfg_base | input | AW | First address of the run and the return point of the window |
| cfg_len | input | LW | Number of addresses to produce |
| cfg_hold_en | input | 1 | 1 selects the wrapping window, 0 selects linear stepping |
| cfg_win_code | input | 2 | Base-2 logarithm of the window size |
| addr_valid | output | 1 | An address is offered |
| addr_ready | input | 1 | The consumer takes the offered address at this edge |
| addr_out | output | AW | Offered address |
| done | output | 1 | One-cycle pulse after the run completes |

## Verification
The address stream is exercised with linear runs that carry a nonzero window code, to show that the code is ignored when hold is clear. Hold runs use every window code, so that a wrong wrap point or a wrong mask width shows up as a wrong address. An unaligned base with a window of 2, and a linear run that crosses the top of the address space, separate "return to base" from "align down" and expose any truncation of the sum. Runs with alternating ready gaps test that an address is never skipped or advanced under stall. The remaining cases are a zero count, and a second start with different settings fired mid-run, which tests that the loaded configuration is frozen and that no run is queued behind it.

// File: rtl/agen_pkg.sv
package agen_pkg;

  localparam int WIN_CODE_W = 2;
  localparam int WIN_OFF_W  = 3;

  typedef enum logic {
    AG_IDLE = 1'b0,
    AG_RUN  = 1'b1
  } ag_state_e;

  // window mask for a code: size 2^code, mask = size-1
  function automatic logic [WIN_OFF_W-1:0] win_mask(input logic [WIN_CODE_W-1:0] code);
    logic [WIN_OFF_W-1:0] m;
    case (code)
      2'd0:    m = 3'b000;
      2'd1:    m = 3'b001;
      2'd2:    m = 3'b011;
      default: m = 3'b111;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/agen_win_decode.sv
module agen_win_decode
  import agen_pkg::*;
(
  input  logic                  hold_en,
  input  logic [WIN_CODE_W-1:0] win_code,
  output logic                  hold,
  output logic [WIN_OFF_W-1:0]  mask
);

  always_comb begin
    hold = hold_en;
    mask = hold_en ? win_mask(win_code) : '1;
  end

endmodule

// File: rtl/agen_seq.sv
module agen_seq
  import agen_pkg::*;
#(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] len_in,
  input  logic          ready,
  output logic          valid,
  output logic          done,
  output logic          load,
  output logic          step
);

  ag_state_e     state_q;
  logic [LW-1:0] rem_q;
  logic          done_q;

  assign valid = (state_q == AG_RUN);
  assign load  = start && (state_q == AG_IDLE);
  assign step  = valid && ready;
  assign done  = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= AG_IDLE;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        AG_IDLE: begin
          if (start) begin
            if (len_in == '0) begin
              done_q <= 1'b1;
            end else begin
              state_q <= AG_RUN;
              rem_q   <= len_in;
            end
          end
        end
        AG_RUN: begin
          if (step) begin
            rem_q <= rem_q - LW'(1);
            if (rem_q == LW'(1)) begin
              state_q <= AG_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        default: state_q <= AG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/agen_offset.sv
module agen_offset
  import agen_pkg::*;
#(
  parameter int AW           = 32,
  parameter bit HOLD_SUPPORT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 step,
  input  logic                 hold_in,
  input  logic [WIN_OFF_W-1:0] mask_in,
  output logic [AW-1:0]        offset,
  output logic                 hold_q,
  output logic [WIN_OFF_W-1:0] mask_q
);

  logic [AW-1:0] off_q;
  logic [AW-1:0] off_next;

  generate
    if (HOLD_SUPPORT) begin : g_hold
      logic [WIN_OFF_W-1:0] win_next;
      logic                 hold_r;
      logic [WIN_OFF_W-1:0] mask_r;

      assign win_next = (off_q[WIN_OFF_W-1:0] + WIN_OFF_W'(1)) & mask_r;
      assign off_next = hold_r ? {{(AW-WIN_OFF_W){1'b0}}, win_next}
                               : off_q + AW'(1);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          hold_r <= 1'b0;
          mask_r <= '1;
        end else if (load) begin
          hold_r <= hold_in;
          mask_r <= mask_in;
        end
      end

      assign hold_q = hold_r;
      assign mask_q = mask_r;
    end else begin : g_linear
      assign off_next = off_q + AW'(1);
      assign hold_q   = 1'b0;
      assign mask_q   = '1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (load) begin
      off_q <= '0;
    end else if (step) begin
      off_q <= off_next;
    end
  end

  assign offset = off_q;

endmodule

// File: rtl/dma_addr_hold_gen.sv
module dma_addr_hold_gen
  import agen_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [AW-1:0]         cfg_base,
  input  logic [LW-1:0]         cfg_len,
  input  logic                  cfg_hold_en,
  input  logic [WIN_CODE_W-1:0] cfg_win_code,
  output logic                  addr_valid,
  input  logic                  addr_ready,
  output logic [AW-1:0]         addr_out,
  output logic                  done
);

  logic                 load;
  logic                 step;
  logic                 dec_hold;
  logic [WIN_OFF_W-1:0] dec_mask;
  logic [AW-1:0]        offset;
  logic                 hold_q;
  logic [WIN_OFF_W-1:0] mask_q;
  logic [AW-1:0]        base_q;

  agen_win_decode u_dec (
    .hold_en  (cfg_hold_en),
    .win_code (cfg_win_code),
    .hold     (dec_hold),
    .mask     (dec_mask)
  );

  agen_seq #(.LW(LW)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .len_in (cfg_len),
    .ready  (addr_ready),
    .valid  (addr_valid),
    .done   (done),
    .load   (load),
    .step   (step)
  );

  agen_offset #(.AW(AW), .HOLD_SUPPORT(1'b1)) u_off (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .hold_in (dec_hold),
    .mask_in (dec_mask),
    .offset  (offset),
    .hold_q  (hold_q),
    .mask_q  (mask_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (load) begin
      base_q <= cfg_base;
    end
  end

  assign addr_out = base_q + offset;

endmodule

// File: rtl/agen_checker.sv
module agen_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          addr_valid,
  input logic          addr_ready,
  input logic [AW-1:0] addr_out,
  input logic          done,
  input logic [AW-1:0] base_q,
  input logic          hold_q,
  input logic [2:0]    mask_q
);

  logic [AW-1:0] rel;
  assign rel = addr_out - base_q;

  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> addr_valid && $stable(addr_out));

  a_r7_done_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !addr_valid);

  a_r7_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(addr_valid && addr_ready) || $past(start));

  a_r4_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && hold_q |-> rel <= AW'(mask_q));

  a_r2_first_base: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_valid) |-> addr_out == base_q);

  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> $stable(base_q) && $stable(hold_q) && $stable(mask_q));

endmodule

bind dma_addr_hold_gen agen_checker #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .addr_valid (addr_valid),
  .addr_ready (addr_ready),
  .addr_out   (addr_out),
  .done       (done),
  .base_q     (base_q),
  .hold_q     (hold_q),
  .mask_q     (mask_q)
);

// File: tb/dma_addr_hold_gen_bench.sv
module dma_addr_hold_gen_bench;

  localparam int AW = 32;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [LW-1:0] cfg_len = '0;
  logic          cfg_hold_en = 1'b0;
  logic [1:0]    cfg_win_code = '0;
  logic          addr_valid;
  logic          addr_ready = 1'b0;
  logic [AW-1:0] addr_out;
  logic          done;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dma_addr_hold_gen #(.AW(AW), .LW(LW)) u_dma_addr_hold_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .cfg_base     (cfg_base),
    .cfg_len      (cfg_len),
    .cfg_hold_en  (cfg_hold_en),
    .cfg_win_code (cfg_win_code),
    .addr_valid   (addr_valid),
    .addr_ready   (addr_ready),
    .addr_out     (addr_out),
    .done         (done)
  );

  // base[51:20] len[19:4] hold[3] code[2:1] stall[0]
  localparam int NV = 6;
  localparam logic [51:0] VEC [NV] = '{
    {32'h0000_1000, 16'd10, 1'b0, 2'd3, 1'b0},
    {32'h0000_2000, 16'd11, 1'b1, 2'd2, 1'b0},
    {32'h0000_3003, 16'd9,  1'b1, 2'd1, 1'b1},
    {32'h0000_4000, 16'd5,  1'b1, 2'd0, 1'b0},
    {32'hFFFF_FFFE, 16'd6,  1'b0, 2'd0, 1'b1},
    {32'h0000_5005, 16'd20, 1'b1, 2'd3, 1'b1}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R3";
      1: return "R4";
      2: return "R6";
      3: return "R4";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input int k,
                                             input logic h, input logic [1:0] c);
    int off;
    off = h ? (k % (1 << c)) : k;
    return b + AW'(off);
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic run_one(input logic [AW-1:0] b, input int len, input logic h,
                         input logic [1:0] c, input bit stall, input string tag);
    int k;
    int cyc;
    logic rdy;
    @(negedge clk);
    cfg_base = b; cfg_len = LW'(len); cfg_hold_en = h; cfg_win_code = c;
    start = 1'b1; addr_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    k = 0; cyc = 0;
    while (k < len && cyc < 200) begin
      rdy = stall ? (cyc % 2 == 1) : 1'b1;
      check((k == 0) ? "R2" : tag, {addr_valid, addr_out}, {1'b1, exp_addr(b, k, h, c)});
      addr_ready = rdy;
      @(negedge clk);
      if (rdy) k++;
      cyc++;
    end
    addr_ready = 1'b0;
    check((len == 0) ? "R8" : "R7", AW'({done, addr_valid}), AW'(2'b10));
    @(negedge clk);
    check((len == 0) ? "R8" : "R7", AW'({done, addr_valid}), AW'(2'b00));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", AW'({addr_valid, done}), AW'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", AW'({addr_valid, done}), AW'(0));

    for (int i = 0; i < NV; i++) begin
      run_one(VEC[i][51:20], int'(VEC[i][19:4]), VEC[i][3], VEC[i][2:1], VEC[i][0], vec_tag(i));
    end

    // zero count
    run_one(32'h0000_8000, 0, 1'b0, 2'd0, 1'b0, "R8");

    // start and config changes mid-run are ignored
    begin
      int k;
      @(negedge clk);
      cfg_base = 32'h0000_6000; cfg_len = 16'd6; cfg_hold_en = 1'b1; cfg_win_code = 2'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (k = 0; k < 6; k++) begin
        if (k == 2) begin
          start = 1'b1;
          cfg_base = 32'h0000_7000; cfg_len = 16'd3; cfg_hold_en = 1'b0; cfg_win_code = 2'd3;
        end else begin
          start = 1'b0;
        end
        check((k < 3) ? "R9" : "R10", {addr_valid, addr_out},
              {1'b1, exp_addr(32'h0000_6000, k, 1'b1, 2'd1)});
        addr_ready = 1'b1;
        @(negedge clk);
      end
      start = 1'b0;
      addr_ready = 1'b0;
      check("R9", AW'({done, addr_valid}), AW'(2'b10));
      @(negedge clk);
      check("R9", AW'({done, addr_valid}), AW'(2'b00));
      @(negedge clk);
      check("R9", AW'({done, addr_valid}), AW'(2'b00));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule